// File: doc/BRIEF.md
# Serial Multiply-Accumulate Fully Connected Layer

This block computes one fully connected neural network layer. It has `N_NEURON` neurons, and each one is a single multiply-accumulate unit sized for a hard DSP slice: an 18-bit signed weight, a 27-bit signed activation and a 48-bit signed accumulator. Input activations arrive one per accepted handshake on a serial stream, and every neuron receives the same activation. Each neuron multiplies it by the weight held for that input position. On the first input of a frame a neuron adds the product to its bias. On every later input it adds the product to its running sum.

Once the final input of a frame has been taken, all results are captured together into an output shift register. Each result passes through ReLU and is clamped to the 27-bit signed range so that it can feed a following layer. The results then leave one per handshake, in neuron order.

The accumulators cannot start a new frame until the previous results have been captured. The input ready signal therefore drops while results wait for the shifter. When there are more neurons than inputs, draining the outputs takes longer than collecting a frame, and the upstream source is throttled. Weights and biases are written through an address/data port while the layer is idle.

Top module: `nn_serial_layer`

## Requirements
- R1: After reset the layer holds `m_valid` low and `s_ready` high.
- R2: Output k of a frame equals `bias[k] + sum over i of weight[k][i]*x[i]`, computed in 48-bit signed two's complement with wraparound, then passed through ReLU and clamping.
- R3: Frames do not interfere. The first input of each frame reloads the bias, so a new frame never includes the sums of the previous frame.
- R4: Each frame produces exactly `N_NEURON` outputs in neuron index order 0 to `N_NEURON-1`. `m_last` is high only with the output of the highest-indexed neuron.
- R5: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged on the next cycle.
- R6: A negative accumulator result is output as 0.
- R7: A result above 2^26-1 is output as 2^26-1 (0x3FFFFFF).
- R8: In the cycle after the final input of a frame is accepted, `s_ready` is low. The results stay pending, and `s_ready` stays low, until the shifter is empty or is handing over its final entry.
- R9: When the final output of one frame is taken in the same cycle that the next frame's results are pending, those results are captured in that cycle. `m_valid` stays high with no gap.
- R10: A configuration write with `cfg_we` high is applied as follows. With `cfg_is_bias`=1 it stores the 48-bit `cfg_data` as the bias of neuron `cfg_nrn`. With `cfg_is_bias`=0 it stores `cfg_data[17:0]` as the weight of neuron `cfg_nrn` for input position `cfg_idx`. A write takes effect for every frame that starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_bias | input | 1 | 1 writes a bias, 0 writes a weight |
| cfg_nrn | input | NW | Target neuron index |
| cfg_idx | input | IW | Input position of a weight write |
| cfg_data | input | W_A | Write data; weights use the low W_W bits |
| s_valid | input | 1 | Input activation valid |
| s_ready | output | 1 | Layer can accept an input activation |
| s_data | input | W_X | Signed input activation |
| m_valid | output | 1 | Output activation valid |
| m_ready | input | 1 | Downstream accepts the output |
| m_data | output | W_X | Output activation after ReLU and clamping |
| m_last | output | 1 | Marks the output of the last neuron of a frame |

## Verification
Two events can land in the same cycle: the downstream handshake of a frame's final output and the capture of the next frame's pending accumulator results. This is provoked by running back-to-back frames with the inputs always valid and the output mostly ready. With 6 neurons and 4 inputs, the next frame completes while the shifter is still draining. Whenever the final output is taken while another frame is already fully accepted, the bench expects `m_valid` to stay high on the next cycle, carrying the first result of that frame. The stall of `s_ready` after each final input is checked in the same runs.

// File: rtl/nn_layer_pkg.sv
package nn_layer_pkg;
  localparam int WGT_W = 18;
  localparam int ACT_W = 27;
  localparam int ACC_W = 48;

  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_MAC  = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/nn_mac_neuron.sv
module nn_mac_neuron
  import nn_layer_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int W_W  = WGT_W,
  parameter int W_X  = ACT_W,
  parameter int W_A  = ACC_W,
  parameter int IW   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wgt_we,
  input  logic                  bias_we,
  input  logic [IW-1:0]         wr_idx,
  input  logic [W_A-1:0]        wr_data,
  input  logic                  step,
  input  mac_mode_e             mode,
  input  logic [IW-1:0]         rd_idx,
  input  logic signed [W_X-1:0] x_in,
  output logic signed [W_A-1:0] acc_o
);
  localparam int PW = W_W + W_X;

  logic signed [W_W-1:0] wgt_mem [N_IN];
  logic signed [W_A-1:0] bias_q;
  logic signed [W_A-1:0] acc_q;
  logic signed [W_W-1:0] wgt_rd;
  logic signed [PW-1:0]  prod;
  logic signed [W_A-1:0] prod_ext;

  // weight store: no reset so it maps onto distributed/block RAM
  always_ff @(posedge clk) begin
    if (wgt_we) wgt_mem[wr_idx] <= wr_data[W_W-1:0];
    if (bias_we) bias_q <= wr_data;
  end

  assign wgt_rd   = wgt_mem[rd_idx];
  assign prod     = wgt_rd * x_in;
  assign prod_ext = {{(W_A-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= ((mode == MODE_LOAD) ? bias_q : acc_q) + prod_ext;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/nn_out_shifter.sv
module nn_out_shifter #(
  parameter int N_NEURON = 6,
  parameter int W_X      = 27
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [N_NEURON*W_X-1:0] load_data,
  input  logic                    m_ready,
  output logic                    m_valid,
  output logic [W_X-1:0]          m_data,
  output logic                    m_last
);
  localparam int CW = $clog2(N_NEURON + 1);

  logic [CW-1:0]  cnt_q;
  logic [W_X-1:0] slot_q [N_NEURON];
  logic           shift;

  assign m_valid = (cnt_q != '0);
  assign m_last  = (cnt_q == CW'(1));
  assign m_data  = slot_q[0];
  assign shift   = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(N_NEURON);
    end else if (shift) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  for (genvar g = 0; g < N_NEURON; g++) begin : g_slot
    logic [W_X-1:0] next_val;
    if (g == N_NEURON - 1) begin : g_tail
      assign next_val = '0;
    end else begin : g_body
      assign next_val = slot_q[g+1];
    end
    always_ff @(posedge clk) begin
      if (load) begin
        slot_q[g] <= load_data[g*W_X +: W_X];
      end else if (shift) begin
        slot_q[g] <= next_val;
      end
    end
  end
endmodule

// File: rtl/nn_serial_layer.sv
module nn_serial_layer
  import nn_layer_pkg::*;
#(
  parameter int N_IN     = 4,
  parameter int N_NEURON = 6,
  parameter int W_W      = WGT_W,
  parameter int W_X      = ACT_W,
  parameter int W_A      = ACC_W,
  parameter int IW       = (N_IN > 1) ? $clog2(N_IN) : 1,
  parameter int NW       = (N_NEURON > 1) ? $clog2(N_NEURON) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic           cfg_is_bias,
  input  logic [NW-1:0]  cfg_nrn,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [W_A-1:0] cfg_data,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [W_X-1:0] s_data,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [W_X-1:0] m_data,
  output logic           m_last
);
  localparam logic signed [W_A-1:0] ACT_MAX = {{(W_A-W_X+1){1'b0}}, {(W_X-1){1'b1}}};

  logic [IW-1:0]           in_cnt_q;
  logic                    acc_full_q;
  logic                    step;
  logic                    last_in;
  logic                    capture;
  mac_mode_e               mode;
  logic [N_NEURON*W_X-1:0] act_vec;

  assign s_ready = ~acc_full_q;
  assign step    = s_valid && s_ready;
  assign last_in = (in_cnt_q == IW'(N_IN - 1));
  assign mode    = (in_cnt_q == '0) ? MODE_LOAD : MODE_MAC;
  assign capture = acc_full_q && (!m_valid || (m_last && m_ready));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt_q   <= '0;
      acc_full_q <= 1'b0;
    end else begin
      if (step) in_cnt_q <= last_in ? '0 : in_cnt_q + IW'(1);
      if (step && last_in) acc_full_q <= 1'b1;
      else if (capture)    acc_full_q <= 1'b0;
    end
  end

  for (genvar n = 0; n < N_NEURON; n++) begin : g_nrn
    logic signed [W_A-1:0] acc;
    logic                  sel;

    assign sel = cfg_we && (cfg_nrn == NW'(n));

    nn_mac_neuron #(
      .N_IN(N_IN), .W_W(W_W), .W_X(W_X), .W_A(W_A), .IW(IW)
    ) u_mac (
      .clk     (clk),
      .rst     (rst),
      .wgt_we  (sel && !cfg_is_bias),
      .bias_we (sel && cfg_is_bias),
      .wr_idx  (cfg_idx),
      .wr_data (cfg_data),
      .step    (step),
      .mode    (mode),
      .rd_idx  (in_cnt_q),
      .x_in    (s_data),
      .acc_o   (acc)
    );

    // ReLU followed by clamping to the activation range
    always_comb begin
      if (acc[W_A-1])         act_vec[n*W_X +: W_X] = '0;
      else if (acc > ACT_MAX) act_vec[n*W_X +: W_X] = ACT_MAX[W_X-1:0];
      else                    act_vec[n*W_X +: W_X] = acc[W_X-1:0];
    end
  end

  nn_out_shifter #(
    .N_NEURON(N_NEURON), .W_X(W_X)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (capture),
    .load_data (act_vec),
    .m_ready   (m_ready),
    .m_valid   (m_valid),
    .m_data    (m_data),
    .m_last    (m_last)
  );
endmodule

// File: rtl/nn_layer_checker.sv
module nn_layer_checker #(
  parameter int W_X = 27
) (
  input logic           clk,
  input logic           rst,
  input logic           s_ready,
  input logic           m_valid,
  input logic           m_ready,
  input logic [W_X-1:0] m_data,
  input logic           m_last,
  input logic           acc_full
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!m_valid && s_ready));

  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (rst)
    m_last |-> m_valid);

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r6_never_negative: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !m_data[W_X-1]);

  a_r8_pending_kept: assert property (@(posedge clk) disable iff (rst)
    (acc_full && m_valid && !(m_last && m_ready)) |=> (acc_full && !s_ready));

  a_r9_gapless_handover: assert property (@(posedge clk) disable iff (rst)
    (acc_full && m_valid && m_last && m_ready) |=> m_valid);
endmodule

bind nn_serial_layer nn_layer_checker #(.W_X(W_X)) u_nn_layer_checker (
  .clk      (clk),
  .rst      (rst),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .m_last   (m_last),
  .acc_full (acc_full_q)
);

// File: tb/test_nn_serial_layer.sv
`timescale 1ns/1ps
module test_nn_serial_layer;
  localparam int NI = 4;
  localparam int NN = 6;
  localparam logic [26:0] XMAX = 27'h3FFFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_is_bias = 1'b0;
  logic [2:0]  cfg_nrn = '0;
  logic [1:0]  cfg_idx = '0;
  logic [47:0] cfg_data = '0;
  logic        s_valid = 1'b0, s_ready;
  logic [26:0] s_data = '0;
  logic        m_valid, m_ready = 1'b0, m_last;
  logic [26:0] m_data;

  int n_chk = 0, n_fail = 0;

  logic signed [17:0] wm [NN][NI];
  logic signed [47:0] bm [NN];
  logic [26:0] exp_q [$];
  string       tag_q [$];
  int          out_pos = 0;

  always #2.5 clk = ~clk;

  nn_serial_layer i_nn_serial_layer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_bias(cfg_is_bias),
    .cfg_nrn(cfg_nrn), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] model(input int n, input logic signed [26:0] xs [NI]);
    logic signed [47:0] acc = bm[n];
    for (int i = 0; i < NI; i++) begin
      logic signed [44:0] p = wm[n][i] * xs[i];
      acc = acc + {{3{p[44]}}, p};
    end
    if (acc[47]) return '0;
    if (acc > 48'sh3FFFFFF) return XMAX;
    return acc[26:0];
  endfunction

  task automatic cfg_write(input bit is_bias, input int n, input int idx, input logic [47:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_is_bias = is_bias; cfg_nrn = 3'(n); cfg_idx = 2'(idx); cfg_data = d;
    if (is_bias) bm[n] = d; else wm[n][idx] = d[17:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs frames; single negedge loop drives and checks both sides
  task automatic run_frames(input int nframes, input string tag, input int vpct, input int rpct);
    logic signed [26:0] xs [NI];
    int  fsent = 0, idx = 0;
    bit  hold_chk = 0, gap_chk = 0, stall_chk = 0;
    logic [26:0] held = '0;
    for (int i = 0; i < NI; i++) xs[i] = 27'($urandom);
    while (fsent < nframes || exp_q.size() > 0) begin
      @(negedge clk);
      if (hold_chk) check(m_valid && m_data == held, "R5", {21'd0, m_data}, {21'd0, held});
      if (gap_chk) check(m_valid === 1'b1, "R9", 48'(m_valid), 48'd1);
      if (stall_chk) check(s_ready === 1'b0, "R8", 48'(s_ready), 48'd0);
      hold_chk = 0; gap_chk = 0; stall_chk = 0;
      m_ready = (($urandom % 100) < rpct);
      if (m_valid) begin
        if (m_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R4", {21'd0, m_data}, 48'd0);
          end else begin
            logic [26:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            check(m_data == e, t, {21'd0, m_data}, {21'd0, e});
            check(m_last == (out_pos == NN - 1), "R4", 48'(m_last), 48'(out_pos == NN - 1));
            out_pos = (out_pos == NN - 1) ? 0 : out_pos + 1;
            if (m_last && exp_q.size() > 0) gap_chk = 1;
          end
        end else begin
          hold_chk = 1; held = m_data;
        end
      end
      if (fsent < nframes) begin
        s_valid = (($urandom % 100) < vpct);
        s_data = xs[idx];
        if (s_valid && s_ready) begin
          if (idx == NI - 1) begin
            for (int n = 0; n < NN; n++) begin
              exp_q.push_back(model(n, xs));
              tag_q.push_back(fsent == 0 ? tag : (tag == "R2" ? "R3" : tag));
            end
            stall_chk = 1;
            idx = 0; fsent++;
            for (int i = 0; i < NI; i++) xs[i] = 27'($urandom);
          end else begin
            idx++;
          end
        end
      end else begin
        s_valid = 1'b0;
      end
    end
    @(negedge clk);
    s_valid = 1'b0; m_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(m_valid === 1'b0, "R1", 48'(m_valid), 48'd0);
    check(s_ready === 1'b1, "R1", 48'(s_ready), 48'd1);
    // R10 config port: random weights, moderate biases
    for (int n = 0; n < NN; n++) begin
      cfg_write(1, n, 0, 48'($signed(41'($urandom)) ) );
      for (int i = 0; i < NI; i++) cfg_write(0, n, i, 48'($urandom));
    end
    run_frames(6, "R2", 70, 60);
    // R9: inputs always valid, output mostly ready
    run_frames(8, "R2", 100, 90);
    // R7 saturation: large positive biases, tiny weights
    for (int n = 0; n < NN; n++) begin
      cfg_write(1, n, 0, 48'h4000_0000_0000 - 48'(n));
      for (int i = 0; i < NI; i++) cfg_write(0, n, i, 48'(i + 1));
    end
    run_frames(2, "R7", 90, 70);
    // R6 negative results become zero
    for (int n = 0; n < NN; n++) cfg_write(1, n, 0, 48'hC000_0000_0000 + 48'(n));
    run_frames(2, "R6", 90, 70);
    // R10 rewrite individual weights and biases, then new frames
    for (int n = 0; n < NN; n++) begin
      cfg_write(1, n, 0, 48'(n * 1000) - 48'd2500);
      cfg_write(0, n, n % NI, 48'($urandom % 512));
    end
    run_frames(3, "R10", 80, 80);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule